// File: doc/BRIEF.md
# Bit-Masked Weight Multiply-Accumulate Element

This processing element multiplies an unsigned 8-bit activation by an unsigned 8-bit weight and accumulates the product into a 32-bit partial sum. The multiplier is built as a tree of partial-product rows, one row per weight bit. A per-instance parameter, `WT_MASK`, lists the weight bit positions that are guaranteed to be zero for the layer the instance serves. The rows for those positions are never generated. The remaining rows are packed into a balanced adder tree, so the tree depth depends on the number of unmasked bits and not on the full weight width. A weight with k masked bits therefore costs about the same as an (8−k)-bit multiplier.

Each accepted operand pair either starts a new partial sum or adds into the running one. Masking depends only on the weight, so the activation can be any value. If a weight arrives with a 1 in a masked position, the element multiplies by the masked weight and raises a sticky flag. This lets a mask that was chosen wrongly be detected in the field.

Top module: `masked_mac_pe`

## Requirements
- R1: After reset, `acc_out` is 0 and `mask_err` is 0.
- R2: The product is the unsigned value `(wt_in & ~WT_MASK) * act_in`, zero-extended to 32 bits.
- R3: On a clock edge with `in_valid`=1 and `acc_clear`=1, the accumulator is loaded with the product alone.
- R4: On a clock edge with `in_valid`=1 and `acc_clear`=0, the product is added to the accumulator, and the sum wraps modulo 2^32.
- R5: On a clock edge with `in_valid`=0, `acc_out` and `mask_err` keep their values, whatever `acc_clear`, `act_in` and `wt_in` are.
- R6: `mask_err` becomes 1 after a clock edge where `in_valid`=1 and `wt_in & WT_MASK` is nonzero.
- R7: Once set, `mask_err` stays 1 until reset.
- R8: Bit i of `WT_MASK` set to 1 removes weight bit i. With `WT_MASK`=8'hFF every product is 0. With `WT_MASK`=8'h00 the element is an exact 8×8 multiplier.
- R9: The result of an accepted pair appears on `acc_out` after exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair is accepted this cycle |
| acc_clear | input | 1 | With `in_valid`, start a new sum from this product |
| act_in | input | 8 | Unsigned activation |
| wt_in | input | 8 | Unsigned weight |
| acc_out | output | 32 | Registered partial sum |
| mask_err | output | 1 | Sticky flag: a weight had a 1 in a masked position |

## Verification
The assertions in the module check on every cycle that a load, an add or a hold leaves `acc_out` at the value computed independently from the previous inputs and the mask, and that the flag rises on a mask violation and never falls. Only the bench scenarios show that the mask parameter really reshapes the tree for several distinct masks, including all-zero and all-ones. The bench also covers 32-bit wrap-around after a long run of maximum products, and clearing of the flag by a reset in the middle of a run.

// File: rtl/masked_mac_pe.sv
module masked_mac_pe #(
  parameter int ACT_W = 8,
  parameter int WT_W  = 8,
  parameter int ACC_W = 32,
  parameter logic [WT_W-1:0] WT_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             acc_clear,
  input  logic [ACT_W-1:0] act_in,
  input  logic [WT_W-1:0]  wt_in,
  output logic [ACC_W-1:0] acc_out,
  output logic             mask_err
);
  localparam int PROD_W = ACT_W + WT_W;

  function automatic int count_kept();
    int n = 0;
    for (int i = 0; i < WT_W; i++) if (!WT_MASK[i]) n++;
    return n;
  endfunction

  function automatic int kept_pos(input int k);
    int n = 0;
    for (int i = 0; i < WT_W; i++)
      if (!WT_MASK[i]) begin
        if (n == k) return i;
        n++;
      end
    return 0;
  endfunction

  localparam int KEPT   = count_kept();
  localparam int LVLS   = (KEPT <= 1) ? 0 : $clog2(KEPT);
  localparam int LEAVES = 1 << LVLS;

  logic [PROD_W-1:0] node [0:2*LEAVES-2];
  logic [ACC_W-1:0]  acc_q;
  logic              err_q;

  for (genvar k = 0; k < LEAVES; k++) begin : g_row
    if (k < KEPT) begin : g_live
      localparam int P = kept_pos(k);
      assign node[LEAVES-1+k] =
        {{WT_W{1'b0}}, act_in & {ACT_W{wt_in[P]}}} << P;
    end else begin : g_pad
      assign node[LEAVES-1+k] = '0;
    end
  end

  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_tree
    assign node[n] = node[2*n+1] + node[2*n+2];
  end

  wire [ACC_W-1:0] prod_ext = ACC_W'(node[0]);
  wire             bad_wt   = |(wt_in & WT_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      err_q <= 1'b0;
    end else if (in_valid) begin
      acc_q <= acc_clear ? prod_ext : acc_q + prod_ext;
      err_q <= err_q | bad_wt;
    end
  end

  assign acc_out  = acc_q;
  assign mask_err = err_q;

  a_r3_clear_loads: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && acc_clear |=> acc_out ==
      ACC_W'($past(wt_in) & ~WT_MASK) * ACC_W'($past(act_in)));

  a_r4_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !acc_clear |=> acc_out == $past(acc_out) +
      ACC_W'($past(wt_in) & ~WT_MASK) * ACC_W'($past(act_in)));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(acc_out) && $stable(mask_err));

  a_r6_flag_rises: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ((wt_in & WT_MASK) != '0) |=> mask_err);

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    mask_err |=> mask_err);
endmodule

// File: tb/masked_mac_pe_tb_top.sv
module masked_mac_pe_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam logic [7:0] MASKS [NI] = '{8'h00, 8'hA5, 8'hFF, 8'h0F};

  logic clk = 0, rst_n = 0, in_valid = 0, acc_clear = 0;
  logic [7:0] act_in = 0, wt_in = 0;
  logic [31:0] acc_o [NI];
  logic        err_o [NI];

  int checks = 0, errors = 0;
  logic [31:0] m_acc [NI];
  bit          m_err [NI];
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar g = 0; g < NI; g++) begin : g_dut
    masked_mac_pe #(.WT_MASK(MASKS[g])) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_clear(acc_clear),
      .act_in(act_in), .wt_in(wt_in), .acc_out(acc_o[g]), .mask_err(err_o[g]));
  end

  task automatic check_all(string tag);
    for (int i = 0; i < NI; i++) begin
      checks++;
      if (acc_o[i] !== m_acc[i]) begin
        errors++;
        $display("FAIL %s mask=%h acc actual=%h expected=%h", tag, MASKS[i], acc_o[i], m_acc[i]);
      end
      checks++;
      if (err_o[i] !== m_err[i]) begin
        errors++;
        $display("FAIL %s mask=%h flag actual=%b expected=%b", tag, MASKS[i], err_o[i], m_err[i]);
      end
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NI; i++) begin m_acc[i] = 0; m_err[i] = 0; end
  endtask

  task automatic step(string tag, bit v, bit c, logic [7:0] a, logic [7:0] w, bit chk = 1);
    in_valid = v; acc_clear = c; act_in = a; wt_in = w;
    @(posedge clk);
    if (v)
      for (int i = 0; i < NI; i++) begin
        int unsigned p = int'(w & ~MASKS[i]) * int'(a);
        m_acc[i] = c ? p : m_acc[i] + p;
        if ((w & MASKS[i]) != 0) m_err[i] = 1;
      end
    @(negedge clk);
    if (chk) check_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0;
    model_reset();
    @(negedge clk);
    check_all("R1");
    rst_n = 1;
  endtask

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    check_all("R1");
    rst_n = 1;
    // R3 / R9: load visible after one edge
    step("R3", 1, 1, 8'd3, 8'd10);
    step("R9", 1, 0, 8'd7, 8'd2);
    // R2 / R8: several operand patterns
    step("R2", 1, 1, 8'hFF, 8'hFF);
    step("R8", 1, 0, 8'h80, 8'h5A);
    step("R2", 1, 0, 8'h01, 8'h42);
    // R5: valid low with clear, odd inputs
    step("R5", 0, 1, 8'hFF, 8'hFF);
    step("R5", 0, 0, 8'h12, 8'h34);
    // R6 / R7: violation then clean weights
    do_reset();
    step("R6", 1, 1, 8'd9, 8'h10);
    step("R7", 1, 0, 8'd9, 8'h40);
    step("R7", 1, 0, 8'd9, 8'h00);
    // R4: pseudo-random mix
    begin
      logic [31:0] s = 32'h1234_5678;
      for (int n = 0; n < 200; n++) begin
        s = s * 32'd1664525 + 32'd1013904223;
        step("R4", s[3:0] != 0, s[7:4] == 0, s[15:8], s[23:16]);
      end
    end
    // R1 / R7: reset clears the sticky flag
    do_reset();
    // R4: wrap-around with maximum products
    step("R4", 1, 1, 8'hFF, 8'hFF);
    for (int n = 0; n < 66100; n++) step("R4", 1, 0, 8'hFF, 8'hFF, (n % 1000) == 0);
    step("R4", 1, 0, 8'hFF, 8'hFF);
    step("R8", 1, 0, 8'h55, 8'hC3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule